// File: doc/BRIEF.md
# Two-Process Toggle-Event Mutual Exclusion Arbiter

This block shares one resource between two processes that talk in two-phase signalling. Each process owns three wires: a request line, a grant line and a release line. An event on any of them is a change of level, and rising and falling changes mean the same thing. A process toggles its request line to ask for the resource. The arbiter toggles that process's grant line to hand the resource over. The process toggles its release line when it has finished.

The arbiter is clocked logic. For each input it keeps a register holding the phase of the last event it has consumed. An input whose present level differs from that register has an unconsumed event. Only one process holds the resource at a time. A request from the other process waits, and the resource passes to it on the same clock edge at which the holder's release is sampled. When both requests arrive in the same cycle while the resource is free, the winner alternates from one such tie to the next. Two kinds of protocol misuse set a sticky error flag: a release from a process that does not hold the resource, and a request withdrawn by a second toggle before it was granted.

Inputs are expected to be synchronous to `clk`. The asynchronous active-low reset is released through a two-stage synchronizer inside the block.

Top module: `toggle_mutex`

## Requirements
- R1: A request toggle of either polarity on process p (bit p of `req_tgl_i`, p = 0 or 1), sampled while the resource is free, toggles bit p of `gnt_tgl_o` at that same rising edge. The change is visible one clock cycle after the input changed.
- R2: At most one bit of `gnt_tgl_o` changes on any clock edge.
- R3: After a grant to process p, neither grant bit changes until a toggle of bit p of `rel_tgl_i` has been sampled.
- R4: A request from the other process that is outstanding when the holder's release is sampled is granted on that same edge.
- R5: When both requests are outstanding on an edge where the resource is free, the first such tie after reset goes to process 0. Later ties alternate: 1, 0, and so on.
- R6: During reset and after it, `gnt_tgl_o` is 00 and `proto_err_o` is 0. All phase registers reset to 0, so inputs held at 0 carry no events.
- R7: A release toggle from a process that does not hold the resource sets `proto_err_o` and produces no grant.
- R8: A request that toggles a second time before it is granted sets `proto_err_o`. The request is treated as withdrawn and is never granted.
- R9: `proto_err_o` stays set until the next reset. Arbitration goes on as normal while it is set.
- R10: The holder may toggle its request again while it holds the resource. This sets no error, and the new request is granted once its own release has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_tgl_i | input | 2 | Request lines; bit p belongs to process p; each toggle is one request |
| rel_tgl_i | input | 2 | Release lines; bit p belongs to process p; each toggle gives the resource back |
| gnt_tgl_o | output | 2 | Grant lines; bit p toggles when process p receives the resource |
| proto_err_o | output | 1 | Sticky protocol-misuse flag |

## Verification
The bench works through these cases:
- Simultaneous requests, twice in a row. An arbiter that always favoured one process, or did not flip its tie pointer, would grant the same process both times.
- Handoff on the release edge. A design that went through an idle cycle first would grant one cycle late.
- A request toggled back before it is granted. A level-based design would miss the error and could still grant the cancelled request.
- A holder that re-requests while it holds the resource, and a release from a process that holds nothing. A design that confused the two would either raise a false error or hand out a grant nobody asked for.

// File: rtl/tmx_pkg.sv
package tmx_pkg;
  localparam int unsigned NPROC = 2;

  typedef enum logic [1:0] {
    HOLD_NONE = 2'd0,
    HOLD_P0   = 2'd1,
    HOLD_P1   = 2'd2
  } hold_e;
endpackage

// File: rtl/tmx_rst_sync.sv
module tmx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb shift_d = {shift_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) shift_q <= '0;
    else          shift_q <= shift_d;
  end

  assign rst_n_o = shift_q[STAGES-1];
endmodule

// File: rtl/tmx_phase_trk.sv
// Per-wire phase tracking: an event is outstanding while the line level
// differs from the phase last consumed. With CATCH_REDO set, a second toggle
// of a line whose event was already outstanding is flagged.
module tmx_phase_trk #(
  parameter int unsigned W          = 2,
  parameter bit          CATCH_REDO = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_i,
  input  logic [W-1:0] take_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] redo_o
);
  logic [W-1:0] seen_q, seen_d;

  for (genvar g = 0; g < W; g++) begin : g_ch
    always_comb seen_d[g] = take_i[g] ? line_i[g] : seen_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seen_q[g] <= 1'b0;
      else if (take_i[g]) seen_q[g] <= seen_d[g];
    end

    assign pend_o[g] = line_i[g] ^ seen_q[g];

    if (CATCH_REDO) begin : g_redo
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= line_i[g];
      end
      // toggled this cycle while already outstanding at the previous sample
      assign redo_o[g] = (line_i[g] ^ prev_q) & (prev_q ^ seen_q[g]);
    end else begin : g_noredo
      assign redo_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/tmx_sched.sv
module tmx_sched
  import tmx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPROC-1:0] req_pend_i,
  input  logic [NPROC-1:0] rel_pend_i,
  output logic [NPROC-1:0] fire_o,
  output logic [NPROC-1:0] bad_rel_o,
  output logic [1:0]       hold_o
);
  hold_e hold_q, hold_d;
  logic  tie_q, tie_d;
  logic  own0, own1, release_now, is_free;

  always_comb begin
    own0        = (hold_q == HOLD_P0);
    own1        = (hold_q == HOLD_P1);
    release_now = (own0 & rel_pend_i[0]) | (own1 & rel_pend_i[1]);
    bad_rel_o   = rel_pend_i & ~{own1, own0};
    is_free     = (hold_q == HOLD_NONE) | release_now;

    fire_o = '0;
    tie_d  = tie_q;
    hold_d = hold_q;
    if (release_now) hold_d = HOLD_NONE;
    if (is_free) begin
      unique case (req_pend_i)
        2'b01: fire_o = 2'b01;
        2'b10: fire_o = 2'b10;
        2'b11: begin
          fire_o = tie_q ? 2'b10 : 2'b01;
          tie_d  = ~tie_q;
        end
        default: fire_o = 2'b00;
      endcase
      if (fire_o[0])      hold_d = HOLD_P0;
      else if (fire_o[1]) hold_d = HOLD_P1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= HOLD_NONE;
      tie_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      if (tie_d != tie_q) tie_q <= tie_d;
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/toggle_mutex.sv
module toggle_mutex
  import tmx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_tgl_i,
  input  logic [1:0] rel_tgl_i,
  output logic [1:0] gnt_tgl_o,
  output logic       proto_err_o
);
  logic             srst_n;
  logic [NPROC-1:0] req_pend, req_redo, rel_pend, rel_redo;
  logic [NPROC-1:0] fire, bad_rel;
  logic [1:0]       hold;
  logic [NPROC-1:0] gnt_q, gnt_d;
  logic             err_q, err_d;

  tmx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(srst_n)
  );

  tmx_phase_trk #(.W(NPROC), .CATCH_REDO(1'b1)) u_req (
    .clk(clk), .rst_n(srst_n), .line_i(req_tgl_i), .take_i(fire),
    .pend_o(req_pend), .redo_o(req_redo)
  );

  // every release event is consumed on the edge that samples it
  tmx_phase_trk #(.W(NPROC), .CATCH_REDO(1'b0)) u_rel (
    .clk(clk), .rst_n(srst_n), .line_i(rel_tgl_i), .take_i(rel_pend),
    .pend_o(rel_pend), .redo_o(rel_redo)
  );

  tmx_sched u_sch (
    .clk(clk), .rst_n(srst_n), .req_pend_i(req_pend), .rel_pend_i(rel_pend),
    .fire_o(fire), .bad_rel_o(bad_rel), .hold_o(hold)
  );

  always_comb begin
    gnt_d = gnt_q ^ fire;
    err_d = err_q | (|bad_rel) | (|req_redo) | (|rel_redo);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      gnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (|fire)           gnt_q <= gnt_d;
      if (err_d != err_q)  err_q <= err_d;
    end
  end

  assign gnt_tgl_o   = gnt_q;
  assign proto_err_o = err_q;
endmodule

// File: rtl/tmx_chk.sv
module tmx_chk
  import tmx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] gnt,
  input logic       err,
  input logic [1:0] hold,
  input logic [1:0] rel_pend
);
  AST_ONE_GRANT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != $past(gnt)) |-> $onehot(gnt ^ $past(gnt))); // R2

  AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((hold == HOLD_P0 && !rel_pend[0]) || (hold == HOLD_P1 && !rel_pend[1]))
      |=> $stable(gnt)); // R3

  AST_STRAY_RELEASE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold == HOLD_NONE && rel_pend != 2'b00) |=> err); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (gnt == 2'b00 && !err)); // R6
endmodule

bind toggle_mutex tmx_chk u_chk (
  .clk(clk), .rst_n(srst_n), .gnt(gnt_tgl_o), .err(proto_err_o),
  .hold(hold), .rel_pend(rel_pend)
);

// File: tb/sim_toggle_mutex.sv
`timescale 1ns/1ps
module sim_toggle_mutex;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] r, d;
  logic [1:0] gnt;
  logic       err;
  logic [1:0] eg;
  logic       ee;
  int         cyc = 0;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done_run = 1'b0;

  typedef struct {
    int         at;
    logic [1:0] g;
    logic       e;
    string      tag;
  } item_t;
  item_t exp_q[$];

  always #4 clk = ~clk;

  toggle_mutex u0 (
    .clk(clk), .rst_n(rst_n), .req_tgl_i(r), .rel_tgl_i(d),
    .gnt_tgl_o(gnt), .proto_err_o(err)
  );

  task automatic compare(string tag, logic [1:0] g, logic e);
    n_chk++;
    if (gnt !== g || err !== e) begin
      n_bad++;
      $display("FAIL %s: gnt=%b err=%b expected gnt=%b err=%b", tag, gnt, err, g, e);
    end
  endtask

  task automatic push(int k, string tag);
    item_t it;
    it.at = cyc + k; it.g = eg; it.e = ee; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: samples 2 ns after each rising edge
  always begin
    @(posedge clk);
    #2;
    cyc++;
    while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
      item_t it;
      it = exp_q.pop_front();
      compare(it.tag, it.g, it.e);
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; r = 2'b00; d = 2'b00; eg = 2'b00; ee = 1'b0;
    step(3);
    compare("R6 outputs quiet in reset", 2'b00, 1'b0);
    rst_n = 1'b1;
    step(4);
    compare("R6 idle after reset", 2'b00, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; r = 2'b00; d = 2'b00; eg = 2'b00; ee = 1'b0;
    @(negedge clk);
    do_reset();

    r[0] = ~r[0]; eg[0] = ~eg[0]; push(1, "R1 rising request grants 0"); step(1);
    r[1] = ~r[1]; push(1, "R3 held, 1 waits"); step(1);
    push(1, "R3 still held"); step(2);
    d[0] = ~d[0]; eg[1] = ~eg[1]; push(1, "R4 handoff on release edge"); step(2);
    d[1] = ~d[1]; push(1, "R3 idle after release"); step(2);

    r = r ^ 2'b11; eg[0] = ~eg[0]; push(1, "R5 R2 first tie to 0"); step(2);
    d[0] = ~d[0]; eg[1] = ~eg[1]; push(1, "R4 loser granted after tie"); step(2);
    d[1] = ~d[1]; step(2);
    r = r ^ 2'b11; eg[1] = ~eg[1]; push(1, "R5 R2 second tie to 1"); step(2);
    d[1] = ~d[1]; eg[0] = ~eg[0]; push(1, "R4 loser granted after tie"); step(2);
    d[0] = ~d[0]; step(2);

    r[0] = ~r[0]; eg[0] = ~eg[0]; push(1, "R1 request of other polarity"); step(2);
    r[0] = ~r[0]; push(1, "R10 holder re-request no error"); step(2);
    d[0] = ~d[0]; eg[0] = ~eg[0]; push(1, "R10 re-grant after own release"); step(2);
    d[0] = ~d[0]; step(2);

    r[1] = ~r[1]; eg[1] = ~eg[1]; push(1, "R1 grant to 1"); step(1);
    r[0] = ~r[0]; step(1);
    r[0] = ~r[0]; ee = 1'b1; push(1, "R8 double toggle flags"); step(1);
    d[1] = ~d[1]; push(1, "R8 withdrawn request not granted"); step(4);
    compare("R9 error persists", eg, ee);

    do_reset();
    d[1] = ~d[1]; ee = 1'b1; push(1, "R7 stray release flags, no grant"); step(2);
    r[0] = ~r[0]; eg[0] = ~eg[0]; push(1, "R9 flag kept, arbitration goes on"); step(2);
    do_reset();
    compare("R9 reset clears flag", 2'b00, 1'b0);

    step(2);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R1: %0d expectations left unchecked, expected 0", exp_q.size());
    end
    done_run = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done_run) begin
      n_chk++; n_bad++;
      $display("FAIL R1: watchdog expired, run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule